// File: doc/BRIEF.md
# Two-Way Doorbell and Mailbox Register Unit

This block is a register mailbox that lets a remote bus master (the host side) and a local processor (the local side) signal each other. Each direction has a 32-bit doorbell register, whose bits are raised by the sending side and acknowledged by the receiving side. Each direction also has a set of message slots. A slot holds a data word and a pending flag.

Every side has its own register access port. The port index identifies the side: index 0 is local and index 1 is host. Both ports can issue one access per clock cycle, at the same time. A read returns its data in the same cycle, combinationally from the registers. A write, or a read that has a side effect, takes effect at the next rising clock edge. Two interrupt outputs report pending work: `irq_local` toward the local processor and `irq_host` toward the host. Each side can mask its own interrupt sources.

The direction index `d` is 0 for inbound (host to local) and 1 for outbound (local to host). The receiving side of direction `d` is side `d`. The sending side is side `1-d`.

Address map with the default two slots per direction:

| Address | Register |
|---|---|
| 0 | inbound doorbell |
| 1 | outbound doorbell |
| 2, 3 | inbound slots 0 and 1 |
| 4, 5 | outbound slots 0 and 1 |
| 6 | pending status |
| 7 | the accessing side's own mask register |

The pending status register holds the inbound flags in bits 0 and 1 and the outbound flags in bits 2 and 3.

Top module: `mbox_unit`

## Requirements
- R1: After reset, all doorbell bits, slot data, pending flags and masks are zero, both interrupts are low, and every read returns zero.
- R2: A host write to address 0 ORs the written ones into the inbound doorbell. Zero bits in the written word leave the doorbell unchanged.
- R3: A local write to address 0 clears each inbound doorbell bit written as one. Zero bits leave the doorbell unchanged.
- R4: A local write to address 1 ORs ones into the outbound doorbell. A host write to address 1 clears each bit written as one.
- R5: When a set from the sending side and a clear from the receiving side hit the same doorbell bit in one cycle, the bit ends set.
- R6: A write by the sending side to a slot stores the word and sets that slot's pending flag. The flag appears in the status register at address 6: bit k for inbound slot k, bit 2+k for outbound slot k.
- R7: A read of a slot by its receiving side returns the word and clears the slot's flag. A read by the sending side, or a read of the status register, leaves flags unchanged.
- R8: Writing a one to a status bit clears the flag only if the writer is that slot's receiving side. Writes by the receiving side to a slot are ignored.
- R9: If a sending-side write and a receiving-side read hit the same slot in one cycle, the read returns the old word, the new word is stored, and the flag stays set.
- R10: Each interrupt output is computed from its own direction's sources: the doorbell source, active while that doorbell is nonzero and mask bit 0 is clear, and slot source k, active while flag k is set and mask bit k+1 is clear. `irq_local` is high exactly when any inbound source is active, and `irq_host` exactly when any outbound source is active. The output changes in the cycle right after the edge that changed its sources.
- R11: The mask register at address 7 is banked per side, so each side reads and writes only its own copy. A masked source keeps its doorbell bits and flags readable. Clearing the mask bit raises the interrupt again.
- R12: Addresses 8 and above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Access request per side (bit 0 local, bit 1 host) |
| req_write | input | 2 | Per side: 1 = write, 0 = read |
| req_addr | input | 2 x AW | Register address per side |
| req_wdata | input | 2 x DW | Write data per side |
| rsp_rdata | output | 2 x DW | Combinational read data per side |
| irq_local | output | 1 | Interrupt toward the local processor |
| irq_host | output | 1 | Interrupt toward the host |

## Verification
Because both sides have their own port, two operations on the same register can land in the same cycle. The first case is a sending side setting a doorbell bit while the receiving side writes one to clear it. The second is a sending side loading a slot while the receiving side reads that slot. The bench drives both ports in a single cycle to provoke each case. It then judges the result from later reads: the doorbell bit must remain set, the read must have returned the old word, and the flag and the new word must both be present afterwards.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int SIDE_LOCAL = 0;
    localparam int SIDE_HOST  = 1;

    // doorbell of direction d sits at address d
    function automatic int unsigned slot_addr(input int unsigned d, input int unsigned k,
                                              input int unsigned nmsg);
        return 2 + d * nmsg + k;
    endfunction

    function automatic int unsigned stat_addr(input int unsigned nmsg);
        return 2 + 2 * nmsg;
    endfunction

    function automatic int unsigned mask_addr(input int unsigned nmsg);
        return 3 + 2 * nmsg;
    endfunction
endpackage

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [DW-1:0] set_bits,
    input  logic          clr_en,
    input  logic [DW-1:0] clr_bits,
    output logic [DW-1:0] bits_q
);
    typedef struct packed {
        logic [DW-1:0] bits;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        logic [DW-1:0] clr_v, set_v;
        clr_v = clr_en ? clr_bits : '0;
        set_v = set_en ? set_bits : '0;
        st_d = st_q;
        // set applied after clear: a colliding set survives
        st_d.bits = (st_q.bits & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;
endmodule

// File: rtl/mbox_msg_slot.sv
module mbox_msg_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_data,
    input  logic          clr_en,
    output logic [DW-1:0] data_q,
    output logic          flag_q
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          flag;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) st_d.data = load_data;
        st_d.flag = load_en | (st_q.flag & ~clr_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.data;
    assign flag_q = st_q.flag;
endmodule

// File: rtl/mbox_irq_merge.sv
module mbox_irq_merge #(
    parameter int DW   = 32,
    parameter int NMSG = 2
) (
    input  logic [DW-1:0]   db_bits,
    input  logic [NMSG-1:0] flags,
    input  logic [NMSG:0]   mask,
    output logic            irq
);
    logic [NMSG:0] src;

    always_comb begin
        src    = '0;
        src[0] = |db_bits;
        src[NMSG:1] = flags;
        irq = |(src & ~mask);
    end
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit #(
    parameter int DW   = 32,
    parameter int AW   = 4,
    parameter int NMSG = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             req_valid,
    input  logic [1:0]             req_write,
    input  logic [1:0][AW-1:0]     req_addr,
    input  logic [1:0][DW-1:0]     req_wdata,
    output logic [1:0][DW-1:0]     rsp_rdata,
    output logic                   irq_local,
    output logic                   irq_host
);
    localparam logic [AW-1:0] A_STAT = AW'(mbox_pkg::stat_addr(NMSG));
    localparam logic [AW-1:0] A_MASK = AW'(mbox_pkg::mask_addr(NMSG));
    localparam int            SW     = 2 * NMSG;

    typedef struct packed {
        logic [1:0][NMSG:0] mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]                     wr, rd;
    logic [1:0][DW-1:0]             db_bits;
    logic [1:0][NMSG-1:0]           flag_q;
    logic [1:0][NMSG-1:0][DW-1:0]   slot_data;
    logic [1:0][NMSG:0]             mask_q;
    logic [1:0]                     irq;

    assign wr = req_valid & req_write;
    assign rd = req_valid & ~req_write;

    // direction d: receiver is side d, sender is side 1-d
    for (genvar d = 0; d < 2; d++) begin : g_dir
        localparam int SND = 1 - d;
        localparam logic [AW-1:0] A_DB = AW'(d);

        mbox_doorbell #(.DW(DW)) u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (wr[SND] && req_addr[SND] == A_DB),
            .set_bits (req_wdata[SND]),
            .clr_en   (wr[d] && req_addr[d] == A_DB),
            .clr_bits (req_wdata[d]),
            .bits_q   (db_bits[d])
        );

        for (genvar k = 0; k < NMSG; k++) begin : g_slot
            localparam logic [AW-1:0] A_SLOT = AW'(mbox_pkg::slot_addr(d, k, NMSG));
            logic load, clr;
            assign load = wr[SND] && req_addr[SND] == A_SLOT;
            assign clr  = (rd[d] && req_addr[d] == A_SLOT) ||
                          (wr[d] && req_addr[d] == A_STAT && req_wdata[d][d*NMSG+k]);

            mbox_msg_slot #(.DW(DW)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_en   (load),
                .load_data (req_wdata[SND]),
                .clr_en    (clr),
                .data_q    (slot_data[d][k]),
                .flag_q    (flag_q[d][k])
            );
        end

        mbox_irq_merge #(.DW(DW), .NMSG(NMSG)) u_irq (
            .db_bits (db_bits[d]),
            .flags   (flag_q[d]),
            .mask    (mask_q[d]),
            .irq     (irq[d])
        );
    end

    // banked mask registers
    always_comb begin
        ctl_d = ctl_q;
        for (int s = 0; s < 2; s++) begin
            if (wr[s] && req_addr[s] == A_MASK) ctl_d.mask[s] = req_wdata[s][NMSG:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mask_q = ctl_q.mask;

    // read mux per side
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            rsp_rdata[s] = '0;
            if (rd[s]) begin
                for (int d = 0; d < 2; d++) begin
                    if (req_addr[s] == AW'(d)) rsp_rdata[s] = db_bits[d];
                    for (int k = 0; k < NMSG; k++) begin
                        if (req_addr[s] == AW'(mbox_pkg::slot_addr(d, k, NMSG)))
                            rsp_rdata[s] = slot_data[d][k];
                    end
                end
                if (req_addr[s] == A_STAT) rsp_rdata[s] = DW'({flag_q[1], flag_q[0]});
                if (req_addr[s] == A_MASK) rsp_rdata[s] = DW'(ctl_q.mask[s]);
            end
        end
    end

    assign irq_local = irq[mbox_pkg::SIDE_LOCAL];
    assign irq_host  = irq[mbox_pkg::SIDE_HOST];

    localparam int UNUSED_SW = SW;
endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk #(
    parameter int DW   = 32,
    parameter int AW   = 4,
    parameter int NMSG = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           req_valid,
    input logic [1:0]           req_write,
    input logic [1:0][AW-1:0]   req_addr,
    input logic [1:0][DW-1:0]   req_wdata,
    input logic [1:0][DW-1:0]   db_bits,
    input logic [1:0][NMSG-1:0] flag_q,
    input logic [1:0][NMSG:0]   mask_q,
    input logic                 irq_local,
    input logic                 irq_host
);
    localparam logic [AW-1:0] A_OUT0 = AW'(mbox_pkg::slot_addr(1, 0, NMSG));

    // host set always lands, even with a colliding local clear
    p_db_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[1] && req_write[1] && req_addr[1] == '0)
        |=> ((db_bits[0] & $past(req_wdata[1])) == $past(req_wdata[1])));

    // without a local write, inbound bits never drop
    p_db_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid[0] && req_write[0] && req_addr[0] == '0)
        |=> ((db_bits[0] & $past(db_bits[0])) == $past(db_bits[0])));

    p_obdb_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && req_write[0] && req_addr[0] == AW'(1))
        |=> ((db_bits[1] & $past(req_wdata[0])) == $past(req_wdata[0])));

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && req_write[0] && req_addr[0] == A_OUT0) |=> flag_q[1][0]);

    p_irq_loc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|db_bits[0]) && !mask_q[0][0]) |-> irq_local);

    p_irq_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|db_bits[1]) && !mask_q[1][0]) |-> irq_host);

    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_local |-> ((|db_bits[0]) || (|flag_q[0])));
endmodule

bind mbox_unit mbox_unit_chk #(.DW(DW), .AW(AW), .NMSG(NMSG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .db_bits   (db_bits),
    .flag_q    (flag_q),
    .mask_q    (mask_q),
    .irq_local (irq_local),
    .irq_host  (irq_host)
);

// File: tb/sim_mbox_unit.sv
module sim_mbox_unit;
    localparam int PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NMSG = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_valid = '0;
    logic [1:0]           req_write = '0;
    logic [1:0][AW-1:0]   req_addr = '0;
    logic [1:0][DW-1:0]   req_wdata = '0;
    logic [1:0][DW-1:0]   rsp_rdata;
    logic                 irq_local, irq_host;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        int          kind;   // 0/1 rdata of side, 2 irq_local, 3 irq_host
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    mbox_unit #(.DW(DW), .AW(AW), .NMSG(NMSG)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .irq_local(irq_local), .irq_host(irq_host)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rsp_rdata[0];
                1: act = rsp_rdata[1];
                2: act = {31'd0, irq_local};
                default: act = {31'd0, irq_host};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic drive(input bit v0, input bit w0, input int a0, input logic [31:0] d0,
                         input bit v1, input bit w1, input int a1, input logic [31:0] d1);
        @(posedge clk); #1;
        req_valid = {v1, v0};
        req_write = {w1, w0};
        req_addr  = {AW'(a1), AW'(a0)};
        req_wdata = {d1, d0};
    endtask

    task automatic wr(input int s, input int a, input logic [31:0] d);
        if (s == 0) drive(1, 1, a, d, 0, 0, 0, 0);
        else        drive(0, 0, 0, 0, 1, 1, a, d);
    endtask

    task automatic expect_now(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.due = cyc; it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input int s, input int a, input logic [31:0] e, input string tag);
        if (s == 0) drive(1, 0, a, 0, 0, 0, 0, 0);
        else        drive(0, 0, 0, 0, 1, 0, a, 0);
        expect_now(s, e, tag);
    endtask

    task automatic irq_is(input int s, input bit v, input string tag);
        expect_now(2 + s, {31'd0, v}, tag);
    endtask

    initial begin : watchdog
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(0, 0, 0, "R1 inbound doorbell");
        irq_is(0, 0, "R1 irq_local");
        irq_is(1, 0, "R1 irq_host");
        rd(1, 6, 0, "R1 status");
        rd(0, 7, 0, "R1 local mask");
        rd(1, 4, 0, "R1 outbound slot");

        // R2 host sets inbound doorbell
        wr(1, 0, 32'hF0);
        rd(0, 0, 32'hF0, "R2 set bits");
        irq_is(0, 1, "R10 irq_local from doorbell");
        wr(1, 0, 32'h0F);
        rd(0, 0, 32'hFF, "R2 zeros keep bits");

        // R3 local clears inbound doorbell
        wr(0, 0, 32'h30);
        rd(0, 0, 32'hCF, "R3 w1c");
        irq_is(0, 1, "R10 irq_local still");
        wr(0, 0, 32'hCF);
        rd(1, 0, 32'h0, "R3 cleared");
        irq_is(0, 0, "R10 irq_local low");

        // R4 outbound doorbell
        wr(0, 1, 32'hA5);
        rd(1, 1, 32'hA5, "R4 local set");
        irq_is(1, 1, "R4 irq_host raised");
        wr(1, 1, 32'h05);
        rd(1, 1, 32'hA0, "R4 host w1c");
        wr(1, 1, 32'hA0);
        rd(1, 1, 32'h0, "R4 all cleared");
        irq_is(1, 0, "R4 irq_host low");

        // R5 collision on doorbell
        wr(1, 0, 32'h3);
        drive(1, 1, 0, 32'h3, 1, 1, 0, 32'h1);
        rd(0, 0, 32'h1, "R5 set wins");
        wr(0, 0, 32'h1);
        rd(0, 0, 32'h0, "R5 cleanup");

        // R6 inbound message
        wr(1, 2, 32'hDEADBEEF);
        rd(0, 6, 32'h1, "R6 inbound flag");
        irq_is(0, 1, "R10 irq_local from message");
        // R8 receiver write to slot ignored
        wr(0, 2, 32'h12345678);
        rd(0, 2, 32'hDEADBEEF, "R8 receiver write ignored");
        rd(0, 6, 32'h0, "R7 receiver read clears flag");
        irq_is(0, 0, "R7 irq_local low");

        // R7 sender read leaves flag
        wr(0, 4, 32'h11112222);
        rd(0, 4, 32'h11112222, "R7 sender read");
        irq_is(1, 1, "R6 irq_host from message");
        rd(1, 6, 32'h4, "R7 flag kept");
        rd(1, 4, 32'h11112222, "R7 host read");
        rd(1, 6, 32'h0, "R7 flag cleared");
        irq_is(1, 0, "R7 irq_host low");

        // R8 status write-one-to-clear rules
        wr(1, 3, 32'h33);
        wr(1, 6, 32'hF);
        rd(0, 6, 32'h2, "R8 sender clear ignored");
        wr(0, 6, 32'h2);
        rd(0, 6, 32'h0, "R8 receiver w1c");
        rd(0, 3, 32'h33, "R8 data kept");

        // R9 load and read collide
        drive(1, 0, 2, 0, 1, 1, 2, 32'h55);
        expect_now(0, 32'hDEADBEEF, "R9 read returns old");
        rd(0, 6, 32'h1, "R9 flag stays");
        irq_is(0, 1, "R9 irq_local");
        rd(0, 2, 32'h55, "R9 new value");
        rd(0, 6, 32'h0, "R9 flag cleared");

        // R11 masks
        wr(0, 7, 32'h1);
        wr(1, 0, 32'h8);
        rd(0, 0, 32'h8, "R11 masked status kept");
        irq_is(0, 0, "R11 masked irq_local");
        rd(1, 7, 32'h0, "R11 host mask separate");
        rd(0, 7, 32'h1, "R11 local mask");
        wr(0, 7, 32'h0);
        rd(0, 0, 32'h8, "R11 bits");
        irq_is(0, 1, "R11 unmask raises irq_local");
        wr(0, 0, 32'h8);
        wr(1, 7, 32'h2);
        irq_is(0, 0, "R11 irq_local after clear");
        wr(0, 4, 32'h9);
        rd(1, 6, 32'h4, "R11 masked flag kept");
        irq_is(1, 0, "R11 masked irq_host");
        wr(1, 7, 32'h0);
        rd(1, 6, 32'h4, "R11 flag");
        irq_is(1, 1, "R11 unmask raises irq_host");
        rd(1, 4, 32'h9, "R11 host read");
        rd(1, 6, 32'h0, "R11 cleared");
        irq_is(1, 0, "R11 irq_host low");

        // R12 unmapped addresses
        wr(0, 9, 32'hFFFF);
        rd(0, 9, 32'h0, "R12 unmapped read");
        rd(0, 0, 32'h0, "R12 doorbell untouched");
        irq_is(0, 0, "R12 irq_local");
        rd(1, 12, 32'h0, "R12 host unmapped");
        rd(1, 7, 32'h0, "R12 host mask untouched");

        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule